// File: doc/BRIEF.md
# SPI Burst Register Port

This block is an SPI slave that lets an external master read and write a 32-bit register space. Every transaction sits inside one chip-select frame. The master first shifts in a 32-bit control word. That word names the direction, the start address and, for reads, how many words to return. A data phase of any number of 32-bit words follows. On a write, each completed word is stored at the next address. On a read, the slave fetches words from consecutive addresses and shifts them out while the master sends filler bytes.

The SPI pins are brought into the system clock domain through a synchronizer, and all protocol logic runs on the system clock. The SPI clock must therefore be slow compared with that clock: each half period of the SPI clock must last at least eight system clock cycles. Register access uses a simple strobe bus. A write is one cycle of `bus_wr_en` together with the address and the data. A read is one cycle of `bus_rd_en` together with the address, and `bus_rdata` must hold the addressed word in the following cycle. Only SPI mode 0 is supported. In this mode the master changes MOSI while the clock is low and samples MISO on the rising edge, and both lines carry the most significant bit first.

Top module: `spi_burst_regport`

## Requirements
- R1: While chip select is high, and after reset, the block issues no bus strobes and drives MISO low. MISO also stays low for the whole control word.
- R2: The control word is shifted in MSB first and is decoded as follows:
  - bit 31 = 1 selects a write and 0 selects a read;
  - bits 30:25 hold the read word count;
  - bits ADDR_W-1:0 hold the start word address.
- R3: In a write frame, each completed 32-bit data word (MSB first) produces exactly one `bus_wr_en` pulse. The first word goes to the start address and each later word goes to the previous address plus one.
- R4: In a read frame with count N greater than 0, the block issues `bus_rd_en` for the start address and the N-1 following addresses, taking `bus_rdata` one cycle after each strobe. Word k is shifted out MSB first on MISO. Its first bit is valid after the falling SPI clock edge that follows the last bit of the previous word, or of the control word for k = 0.
- R5: A read frame issues exactly N read strobes. Words clocked beyond the count return zero, and a count of 0 issues no read at all.
- R6: When chip select rises in the middle of a word, that partial word is discarded and produces no strobe. The next frame starts decoding a fresh control word, even if the cut came inside the control word.
- R7: A write frame issues no read strobe and keeps MISO low. A read frame issues no write strobe, whatever data the master sends on MOSI.
- R8: The word address increments modulo 2^ADDR_W, so a burst passing the top address continues at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI clock from the master (mode 0) |
| spi_cs_n | input | 1 | Chip select, active low, frames one transaction |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| bus_wr_en | output | 1 | One-cycle register write strobe |
| bus_rd_en | output | 1 | One-cycle register read strobe |
| bus_addr | output | ADDR_W | Word address for the current strobe |
| bus_wdata | output | 32 | Write data, valid with bus_wr_en |
| bus_rdata | input | 32 | Read data, valid the cycle after bus_rd_en |

## Verification
A wrong phase or bit counter shows up at the bus within one word: a strobe arrives early or late, goes to the wrong address, or carries bits that are shifted by one position. A wrong remaining-count or address register shows on the MISO stream of that same frame, as a stale or extra word, a nonzero tail, or an address that is not consecutive. Partial-word state that survives a chip-select rise corrupts the control word of the very next frame, so every truncation test is followed immediately by a full transaction that is checked word by word.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    localparam int WORD_W  = 32;
    localparam int DIR_BIT = 31;
    localparam int CNT_LSB = 25;
    localparam int CNT_W   = 6;

    typedef enum logic [1:0] {
        PH_CTRL  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2
    } phase_e;

    function automatic logic ctl_is_write(input logic [WORD_W-1:0] w);
        return w[DIR_BIT];
    endfunction

    function automatic logic [CNT_W-1:0] ctl_count(input logic [WORD_W-1:0] w);
        return w[CNT_LSB +: CNT_W];
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s,
    output logic cs_act
);
    logic [STAGES-1:0] sclk_p;
    logic [STAGES-1:0] mosi_p;
    logic [STAGES-1:0] csn_p;
    logic              sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_p <= '0;
            mosi_p <= '0;
            csn_p  <= '1;
            sclk_d <= 1'b0;
        end else begin
            sclk_p <= {sclk_p[STAGES-2:0], spi_sclk};
            mosi_p <= {mosi_p[STAGES-2:0], spi_mosi};
            csn_p  <= {csn_p[STAGES-2:0], spi_cs_n};
            sclk_d <= sclk_p[STAGES-1];
        end
    end

    assign sclk_rise = sclk_p[STAGES-1] & ~sclk_d;
    assign sclk_fall = ~sclk_p[STAGES-1] & sclk_d;
    assign mosi_s    = mosi_p[STAGES-1];
    assign cs_act    = ~csn_p[STAGES-1];

endmodule

// File: rtl/spi_rx_word.sv
module spi_rx_word
    import spi_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              mosi_s,
    output logic              word_done,
    output logic [WORD_W-1:0] word
);
    localparam int BCNT_W = $clog2(WORD_W);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(WORD_W - 1);

    logic [WORD_W-2:0] rx_sh;
    logic [BCNT_W-1:0] bit_cnt;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            rx_sh   <= '0;
            bit_cnt <= '0;
        end else if (sclk_rise) begin
            rx_sh   <= {rx_sh[WORD_W-3:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign word      = {rx_sh, mosi_s};
    assign word_done = cs_act && sclk_rise && (bit_cnt == LAST_BIT);

endmodule

// File: rtl/spi_tx_word.sv
module spi_tx_word
    import spi_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              sclk_fall,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    output logic              miso
);
    logic [WORD_W-1:0] tx_sh;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            tx_sh <= '0;
            miso  <= 1'b0;
        end else if (load) begin
            tx_sh <= load_data;
        end else if (sclk_fall) begin
            miso  <= tx_sh[WORD_W-1];
            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/spi_burst_regport.sv
module spi_burst_regport
    import spi_burst_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              bus_wr_en,
    output logic              bus_rd_en,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    logic              sclk_rise, sclk_fall, mosi_s, cs_act;
    logic              word_done;
    logic [WORD_W-1:0] word;

    phase_e            phase;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] baddr_q;
    logic [WORD_W-1:0] wdata_q;
    logic [CNT_W-1:0]  left_q;
    logic              wr_q, rd_q, fetch_q;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s),
        .cs_act    (cs_act)
    );

    spi_rx_word u_rx (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .mosi_s    (mosi_s),
        .word_done (word_done),
        .word      (word)
    );

    spi_tx_word u_tx (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (cs_act),
        .sclk_fall (sclk_fall),
        .load      (fetch_q),
        .load_data (bus_rdata),
        .miso      (spi_miso)
    );

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            phase   <= PH_CTRL;
            addr_q  <= '0;
            baddr_q <= '0;
            wdata_q <= '0;
            left_q  <= '0;
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            fetch_q <= 1'b0;
        end else begin
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            fetch_q <= rd_q;
            if (word_done) begin
                case (phase)
                    PH_CTRL: begin
                        addr_q <= word[ADDR_W-1:0];
                        if (ctl_is_write(word)) begin
                            phase <= PH_WRITE;
                        end else begin
                            phase <= PH_READ;
                            if (ctl_count(word) != '0) begin
                                rd_q    <= 1'b1;
                                baddr_q <= word[ADDR_W-1:0];
                                addr_q  <= word[ADDR_W-1:0] + ADDR_ONE;
                                left_q  <= ctl_count(word) - CNT_ONE;
                            end
                        end
                    end
                    PH_WRITE: begin
                        wr_q    <= 1'b1;
                        baddr_q <= addr_q;
                        wdata_q <= word;
                        addr_q  <= addr_q + ADDR_ONE;
                    end
                    PH_READ: begin
                        if (left_q != '0) begin
                            rd_q    <= 1'b1;
                            baddr_q <= addr_q;
                            addr_q  <= addr_q + ADDR_ONE;
                            left_q  <= left_q - CNT_ONE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign bus_wr_en = wr_q;
    assign bus_rd_en = rd_q;
    assign bus_addr  = baddr_q;
    assign bus_wdata = wdata_q;

endmodule

// File: rtl/spi_burst_chk.sv
module spi_burst_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_act,
    input logic              spi_miso,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic [ADDR_W-1:0] bus_addr
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic              seen;
    logic [ADDR_W-1:0] last_addr;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            seen      <= 1'b0;
            last_addr <= '0;
        end else if (bus_wr_en || bus_rd_en) begin
            seen      <= 1'b1;
            last_addr <= bus_addr;
        end
    end

    p_strobe_in_frame_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en || bus_rd_en) |-> $past(cs_act));

    p_miso_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !spi_miso);

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr_en || bus_rd_en) && seen) |-> (bus_addr == last_addr + ADDR_ONE));

    p_single_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr_en && bus_rd_en));

endmodule

bind spi_burst_regport spi_burst_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .spi_miso  (spi_miso),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr)
);

// File: tb/tb_spi_burst_regport.sv
`timescale 1ns/1ps
module tb_spi_burst_regport;
    localparam int HALF = 8;

    typedef struct packed {
        logic        wr;
        logic [5:0]  cnt;
        logic [15:0] addr;
        logic [3:0]  nwords;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 6'd0, 16'h0010, 4'd1},
        '{1'b1, 6'd0, 16'h0100, 4'd4},
        '{1'b0, 6'd1, 16'h0020, 4'd1},
        '{1'b0, 6'd3, 16'h0300, 4'd3},
        '{1'b0, 6'd2, 16'h0040, 4'd4},
        '{1'b1, 6'd0, 16'hFFFF, 4'd2},
        '{1'b0, 6'd0, 16'h0050, 4'd1},
        '{1'b0, 6'd3, 16'hFFFE, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        bus_wr_en, bus_rd_en;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int          wr_cnt = 0;
    int          rd_cnt = 0;
    logic [15:0] wlog_a [16];
    logic [31:0] wlog_d [16];

    always #10 clk = ~clk;

    spi_burst_regport dut (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .bus_wr_en(bus_wr_en),
        .bus_rd_en(bus_rd_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] rd_pat(input logic [15:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction

    function automatic logic [31:0] wr_pat(input int k, input int i);
        return (32'(k) * 32'h9E3779B1) ^ (32'(i) * 32'h01030507) ^ 32'h80000001;
    endfunction

    always_ff @(posedge clk) begin
        if (bus_rd_en) bus_rdata <= rd_pat(bus_addr);
        if (bus_wr_en) begin
            wlog_a[wr_cnt[3:0]] <= bus_addr;
            wlog_d[wr_cnt[3:0]] <= bus_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (bus_rd_en) rd_cnt <= rd_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic spi_bits(input logic [31:0] v, input int n, output logic [31:0] r);
        r = '0;
        for (int b = 0; b < n; b++) begin
            spi_mosi = v[31-b];
            repeat (HALF) @(negedge clk);
            r = {r[30:0], spi_miso};
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic cs_low();
        spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (4) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    function automatic logic [31:0] ctl_wr(input logic [15:0] a);
        return {1'b1, 6'd0, 9'd0, a};
    endfunction

    function automatic logic [31:0] ctl_rd(input logic [5:0] c, input logic [15:0] a);
        return {1'b0, c, 9'd0, a};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rx;
        logic [31:0] exp;
        logic [15:0] a;
        int w0, r0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk("R1 reset miso", 32'(spi_miso), 32'd0);
        chk("R1 reset wr strobes", 32'(wr_cnt), 32'd0);
        chk("R1 reset rd strobes", 32'(rd_cnt), 32'd0);

        for (int k = 0; k < 8; k++) begin
            w0 = wr_cnt;
            r0 = rd_cnt;
            cs_low();
            spi_bits(VECS[k].wr ? ctl_wr(VECS[k].addr) : ctl_rd(VECS[k].cnt, VECS[k].addr), 32, rx);
            chk("R1 miso low in control", rx, 32'd0);
            for (int i = 0; i < int'(VECS[k].nwords); i++) begin
                a = VECS[k].addr + 16'(i);
                if (VECS[k].wr) begin
                    spi_bits(wr_pat(k, i), 32, rx);
                    chk("R7 miso low in write", rx, 32'd0);
                end else begin
                    spi_bits(32'hFFFFFFFF, 32, rx);
                    exp = (i < int'(VECS[k].cnt)) ? rd_pat(a) : 32'd0;
                    chk((i >= int'(VECS[k].cnt)) ? "R5 tail zero" : ((a == 16'h0 && i > 0) ? "R8 read wrap" : "R4 read data"), rx, exp);
                end
            end
            cs_high();
            chk("R1 miso low after frame", 32'(spi_miso), 32'd0);
            if (VECS[k].wr) begin
                chk("R3 write strobe count", 32'(wr_cnt - w0), 32'(VECS[k].nwords));
                chk("R7 no read in write", 32'(rd_cnt - r0), 32'd0);
                for (int i = 0; i < int'(VECS[k].nwords); i++) begin
                    a = VECS[k].addr + 16'(i);
                    chk((i == 0) ? "R2 start address" : ((a == 16'h0) ? "R8 write wrap" : "R3 next address"),
                        32'(wlog_a[4'(w0 + i)]), 32'(a));
                    chk("R3 write data", wlog_d[4'(w0 + i)], wr_pat(k, i));
                end
            end else begin
                chk("R5 read strobe count", 32'(rd_cnt - r0), 32'(VECS[k].cnt));
                chk("R7 no write in read", 32'(wr_cnt - w0), 32'd0);
            end
        end

        // R6: cut inside a data word
        w0 = wr_cnt;
        cs_low();
        spi_bits(ctl_wr(16'h0030), 32, rx);
        spi_bits(32'hDEADBEEF, 16, rx);
        cs_high();
        chk("R6 partial word dropped", 32'(wr_cnt - w0), 32'd0);
        cs_low();
        spi_bits(ctl_wr(16'h0031), 32, rx);
        spi_bits(32'hCAFEF00D, 32, rx);
        cs_high();
        chk("R6 next frame write count", 32'(wr_cnt - w0), 32'd1);
        chk("R6 next frame address", 32'(wlog_a[4'(w0)]), 32'h0031);
        chk("R6 next frame data", wlog_d[4'(w0)], 32'hCAFEF00D);

        // R6: cut inside the control word
        r0 = rd_cnt;
        w0 = wr_cnt;
        cs_low();
        spi_bits(ctl_wr(16'h0777), 12, rx);
        cs_high();
        cs_low();
        spi_bits(ctl_rd(6'd1, 16'h0007), 32, rx);
        spi_bits(32'hFFFFFFFF, 32, rx);
        cs_high();
        chk("R6 fresh control read data", rx, rd_pat(16'h0007));
        chk("R6 fresh control read count", 32'(rd_cnt - r0), 32'd1);
        chk("R6 no write from cut control", 32'(wr_cnt - w0), 32'd0);

        // R7: MOSI content ignored during a read
        r0 = rd_cnt;
        w0 = wr_cnt;
        cs_low();
        spi_bits(ctl_rd(6'd2, 16'h0123), 32, rx);
        spi_bits(32'h12345678, 32, rx);
        chk("R7 read word0 with data on mosi", rx, rd_pat(16'h0123));
        spi_bits(32'h00000000, 32, rx);
        chk("R7 read word1 with zeros on mosi", rx, rd_pat(16'h0124));
        cs_high();
        chk("R7 no write from mosi data", 32'(wr_cnt - w0), 32'd0);
        chk("R5 read count exact", 32'(rd_cnt - r0), 32'd2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule